// File: doc/BRIEF.md
# Queue Status Interrupt Generator

This block turns the live status flags of a bank of hardware queues into per-queue interrupt bits. Each queue in the lower group has a 4-bit selector field. The selector picks one of eight conditions: one of the four flags (empty, nearly-empty, nearly-full, full) or its inverse. Every queue in the upper group always uses its nearly-empty flag.

A global mode bit picks between two behaviours for the interrupt bits:
- **Sticky mode:** a rising condition latches the bit, and it stays set until software writes a 1 to it.
- **Level mode:** the bit simply mirrors the condition one clock later.

Two enable words mask the interrupt words. Each group drives one registered interrupt output.

Software uses a simple word-wide register port. The port has a write strobe with address and data, and a combinational read by address. Through it software programs the selectors and the enables, reads back the interrupt words and clears pending bits. The queue storage that produces the flags sits outside this block.

Top module: `qstat_irq`

## Requirements
- R1: For lower queue q, the field is selector word q/8, bits [(q%8)*4+3 : (q%8)*4]. Field bits [1:0] pick a flag from `lo_flags[q*4+k]`, where k=0 is empty, k=1 nearly-empty, k=2 nearly-full and k=3 full. Field bit 2 set inverts the flag.
- R2: For upper queue u, the condition is `up_near_empty[u]`, with no selector.
- R3: In sticky mode (bit 3 of selector word 0 = 1), an interrupt bit sets when its condition is 1 now and was 0 on the previous clock. It then holds until a write of 1 to that bit of its interrupt word.
- R4: In sticky mode, a new event and a clear of the same bit on the same clock leave the bit set.
- R5: In level mode (bit 3 of selector word 0 = 0), each interrupt bit equals its condition from the previous clock. Writes to the interrupt words have no effect.
- R6: `irq_lo` / `irq_up` equal the OR over the queues of (interrupt bit AND enable bit) for that group. They update on the same edge as the interrupt bits, one clock after a flag changes.
- R7: Register map, with S = LOW_Q/8: addresses 0..S-1 hold the selector words, S holds the lower enable, S+1 the upper enable, S+2 the lower interrupt word and S+3 the upper interrupt word. All of them read back on `rd_data`.
- R8: After reset, all selector, enable and interrupt words read 0 and both interrupt outputs are 0.
- R9: Bit 3 of every selector field other than queue 0's has no effect on any condition.
- R10: A selector write takes effect from the next clock. A write that turns a false condition true counts as an event in sticky mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lo_flags | input | LOW_Q*4 | Lower queue flags, 4 per queue |
| up_near_empty | input | UPP_Q | Upper queue nearly-empty flags |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq_lo | output | 1 | Lower group interrupt |
| irq_up | output | 1 | Upper group interrupt |

## Verification
A wrong previous-condition sample or latch state shows up at the interrupt word on `rd_data` and at the group output on the clock right after the flag change. It appears either as a bit that sets without a rising condition or as a bit that drops without a clear. A corrupted selector or enable register shows on readback at once, and on the group output one clock after the next flag change for that queue. Because every write also feeds a reference model, a lost clear or a wrong mode shows as a mismatch within one cycle.

// File: rtl/qsi_pkg.sv
// Shared constants and the condition-pick function for the queue status
// interrupt generator. Assumes 32-bit register words.
package qsi_pkg;
    localparam int DATA_W      = 32;
    localparam int FLAGS_PER_Q = 4;
    localparam int FIELD_W     = 4;
    localparam int SEL_USED_W  = 3;
    localparam int Q_PER_SEL   = DATA_W / FIELD_W;

    // Flag order inside each queue's 4-bit status nibble.
    typedef enum logic [1:0] {
        FLAG_EMPTY      = 2'd0,
        FLAG_NEAR_EMPTY = 2'd1,
        FLAG_NEAR_FULL  = 2'd2,
        FLAG_FULL       = 2'd3
    } flag_e;

    // Selected condition: bits [1:0] choose a flag, bit 2 inverts it.
    function automatic logic pick_cond(input logic [FLAGS_PER_Q-1:0] flags,
                                       input logic [SEL_USED_W-1:0] sel);
        flag_e which;
        which = flag_e'(sel[1:0]);
        return flags[which] ^ sel[2];
    endfunction
endpackage

// File: rtl/qsi_cond_sel.sv
// Per-queue condition selector for the lower group. Each queue gets the
// low 3 bits of its selector field; assumes flags are packed 4 per queue.
module qsi_cond_sel #(
    parameter int NQ = 32
) (
    input  logic [NQ*qsi_pkg::FLAGS_PER_Q-1:0] flags,
    input  logic [NQ*qsi_pkg::SEL_USED_W-1:0]  sel_low3,
    output logic [NQ-1:0]                      cond
);
    localparam int FW = qsi_pkg::FLAGS_PER_Q;
    localparam int SW = qsi_pkg::SEL_USED_W;

    // One selector per queue.
    for (genvar q = 0; q < NQ; q++) begin : g_q
        assign cond[q] = qsi_pkg::pick_cond(flags[q*FW +: FW], sel_low3[q*SW +: SW]);
    end
endmodule

// File: rtl/qsi_latch.sv
// Interrupt bit latch for one group of N queues. Sticky mode latches a
// rising condition until write-one-to-clear; level mode registers the
// condition. Assumes synchronous active-low reset.
module qsi_latch #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond,
    input  logic         sticky,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] int_q,
    output logic [N-1:0] int_d
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise;
    logic [N-1:0] clr_eff;

    // Edge detect against the previous sample and form the next value.
    always_comb begin
        rise    = cond & ~prev_q;
        clr_eff = clr_we ? clr_mask : '0;
        if (sticky) begin
            int_d = (int_q & ~clr_eff) | rise;
        end else begin
            int_d = cond;
        end
    end

    // State update; previous sample starts high so reset is not an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q  <= '0;
            prev_q <= '1;
        end else begin
            int_q  <= int_d;
            prev_q <= cond;
        end
    end
endmodule

// File: rtl/qsi_regs.sv
// Software-visible registers: selector words, two enable words and the
// read mux that also returns the interrupt words. Write decode for the
// interrupt-clear strobes lives here. Assumes LOW_Q is a multiple of 8
// and both groups are at most 32 queues.
module qsi_regs #(
    parameter int LOW_Q  = 32,
    parameter int UPP_Q  = 32,
    parameter int ADDR_W = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [ADDR_W-1:0]                      wr_addr,
    input  logic [qsi_pkg::DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]                      rd_addr,
    output logic [qsi_pkg::DATA_W-1:0]             rd_data,
    input  logic [LOW_Q-1:0]                       int_lo,
    input  logic [UPP_Q-1:0]                       int_up,
    output logic [LOW_Q*qsi_pkg::SEL_USED_W-1:0]   sel_low3,
    output logic                                   sticky,
    output logic [LOW_Q-1:0]                       en_lo_q,
    output logic [LOW_Q-1:0]                       en_lo_d,
    output logic [UPP_Q-1:0]                       en_up_q,
    output logic [UPP_Q-1:0]                       en_up_d,
    output logic                                   clr_lo_we,
    output logic                                   clr_up_we
);
    localparam int DW        = qsi_pkg::DATA_W;
    localparam int FW        = qsi_pkg::FIELD_W;
    localparam int SW        = qsi_pkg::SEL_USED_W;
    localparam int QPW       = qsi_pkg::Q_PER_SEL;
    localparam int SEL_WORDS = LOW_Q / QPW;
    localparam int A_EN_LO   = SEL_WORDS;
    localparam int A_EN_UP   = SEL_WORDS + 1;
    localparam int A_INT_LO  = SEL_WORDS + 2;
    localparam int A_INT_UP  = SEL_WORDS + 3;

    logic [SEL_WORDS-1:0][DW-1:0] sel_q;

    // Address decode for enable and clear writes.
    always_comb begin
        en_lo_d   = (wr_en && wr_addr == ADDR_W'(A_EN_LO)) ? wr_data[LOW_Q-1:0] : en_lo_q;
        en_up_d   = (wr_en && wr_addr == ADDR_W'(A_EN_UP)) ? wr_data[UPP_Q-1:0] : en_up_q;
        clr_lo_we = wr_en && wr_addr == ADDR_W'(A_INT_LO);
        clr_up_we = wr_en && wr_addr == ADDR_W'(A_INT_UP);
    end

    // Register storage for selectors and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            en_lo_q <= '0;
            en_up_q <= '0;
        end else begin
            for (int w = 0; w < SEL_WORDS; w++) begin
                if (wr_en && wr_addr == ADDR_W'(w)) begin
                    sel_q[w] <= wr_data;
                end
            end
            en_lo_q <= en_lo_d;
            en_up_q <= en_up_d;
        end
    end

    // Global mode bit sits in bit 3 of selector word 0.
    assign sticky = sel_q[0][3];

    // Low 3 bits of every field feed the condition selectors.
    for (genvar q = 0; q < LOW_Q; q++) begin : g_sel
        assign sel_low3[q*SW +: SW] = sel_q[q / QPW][(q % QPW)*FW +: SW];
    end

    // Combinational readback mux.
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < SEL_WORDS; w++) begin
            if (rd_addr == ADDR_W'(w)) begin
                rd_data = sel_q[w];
            end
        end
        if (rd_addr == ADDR_W'(A_EN_LO))  rd_data = DW'(en_lo_q);
        if (rd_addr == ADDR_W'(A_EN_UP))  rd_data = DW'(en_up_q);
        if (rd_addr == ADDR_W'(A_INT_LO)) rd_data = DW'(int_lo);
        if (rd_addr == ADDR_W'(A_INT_UP)) rd_data = DW'(int_up);
    end
endmodule

// File: rtl/qstat_irq.sv
// Top of the queue status interrupt generator. Lower queues pick their
// trigger through selector fields, upper queues trigger on nearly-empty.
// Assumes LOW_Q is a multiple of 8, both groups at most 32 queues.
module qstat_irq #(
    parameter int LOW_Q = 32,
    parameter int UPP_Q = 32,
    localparam int ADDR_W = $clog2(LOW_Q / qsi_pkg::Q_PER_SEL + 4)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [LOW_Q*qsi_pkg::FLAGS_PER_Q-1:0] lo_flags,
    input  logic [UPP_Q-1:0]                     up_near_empty,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [qsi_pkg::DATA_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [qsi_pkg::DATA_W-1:0]           rd_data,
    output logic                                 irq_lo,
    output logic                                 irq_up
);
    localparam int SW = qsi_pkg::SEL_USED_W;

    logic [LOW_Q*SW-1:0] sel_low3;
    logic                sticky;
    logic [LOW_Q-1:0]    en_lo_q, en_lo_d, int_lo_q, int_lo_d, cond_lo;
    logic [UPP_Q-1:0]    en_up_q, en_up_d, int_up_q, int_up_d;
    logic                clr_lo_we, clr_up_we;

    qsi_regs #(.LOW_Q(LOW_Q), .UPP_Q(UPP_Q), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .int_lo(int_lo_q), .int_up(int_up_q),
        .sel_low3(sel_low3), .sticky(sticky),
        .en_lo_q(en_lo_q), .en_lo_d(en_lo_d),
        .en_up_q(en_up_q), .en_up_d(en_up_d),
        .clr_lo_we(clr_lo_we), .clr_up_we(clr_up_we)
    );

    qsi_cond_sel #(.NQ(LOW_Q)) u_sel (
        .flags(lo_flags), .sel_low3(sel_low3), .cond(cond_lo)
    );

    qsi_latch #(.N(LOW_Q)) u_lat_lo (
        .clk(clk), .rst_n(rst_n), .cond(cond_lo), .sticky(sticky),
        .clr_we(clr_lo_we), .clr_mask(wr_data[LOW_Q-1:0]),
        .int_q(int_lo_q), .int_d(int_lo_d)
    );

    qsi_latch #(.N(UPP_Q)) u_lat_up (
        .clk(clk), .rst_n(rst_n), .cond(up_near_empty), .sticky(sticky),
        .clr_we(clr_up_we), .clr_mask(wr_data[UPP_Q-1:0]),
        .int_q(int_up_q), .int_d(int_up_d)
    );

    // Group outputs registered from next-state values, aligned with the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_lo <= 1'b0;
            irq_up <= 1'b0;
        end else begin
            irq_lo <= |(int_lo_d & en_lo_d);
            irq_up <= |(int_up_d & en_up_d);
        end
    end
endmodule

// File: rtl/qstat_irq_chk.sv
// Property checker for qstat_irq, attached by bind. Observes the latch
// words, enables, mode bit and group outputs.
module qstat_irq_chk #(
    parameter int LOW_Q = 32,
    parameter int UPP_Q = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sticky,
    input logic [LOW_Q-1:0] int_lo,
    input logic [LOW_Q-1:0] en_lo,
    input logic [UPP_Q-1:0] int_up,
    input logic [UPP_Q-1:0] en_up,
    input logic [UPP_Q-1:0] up_ne,
    input logic             clr_lo,
    input logic             clr_up,
    input logic             irq_lo,
    input logic             irq_up
);
    assert_irq_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo == |(int_lo & en_lo));

    assert_irq_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_up == |(int_up & en_up));

    assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sticky)) |-> (int_up == $past(up_ne)));

    assert_sticky_hold_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sticky) && !$past(clr_lo)) |->
        ((int_lo & $past(int_lo)) == $past(int_lo)));

    assert_sticky_hold_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sticky) && !$past(clr_up)) |->
        ((int_up & $past(int_up)) == $past(int_up)));

    assert_sticky_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sticky)) |->
        ((int_up & ~$past(int_up) & ~$past(up_ne)) == '0));
endmodule

bind qstat_irq qstat_irq_chk #(.LOW_Q(LOW_Q), .UPP_Q(UPP_Q)) u_chk (
    .clk(clk), .rst_n(rst_n), .sticky(sticky),
    .int_lo(int_lo_q), .en_lo(en_lo_q),
    .int_up(int_up_q), .en_up(en_up_q),
    .up_ne(up_near_empty),
    .clr_lo(clr_lo_we), .clr_up(clr_up_we),
    .irq_lo(irq_lo), .irq_up(irq_up)
);

// File: tb/qstat_irq_test.sv
// Bench for qstat_irq: directed corner cases followed by seeded random
// traffic, all compared against a reference model built from the brief.
module qstat_irq_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] lo_flags = {32{4'h1}};
    logic [31:0]  up_near_empty = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic         irq_lo, irq_up;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [2:0] rd_ptr = '0;

    // Reference model state.
    logic [31:0] m_sel [4];
    logic [31:0] m_en_lo, m_en_up, m_int_lo, m_int_up, m_prev_lo, m_prev_up;
    logic        m_irq_lo, m_irq_up;

    qstat_irq uut (
        .clk(clk), .rst_n(rst_n), .lo_flags(lo_flags), .up_near_empty(up_near_empty),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_lo(irq_lo), .irq_up(irq_up)
    );

    always #10 clk = ~clk;

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lo_cond();
        logic [31:0] c;
        for (int q = 0; q < 32; q++) begin
            logic [3:0] f;
            f = m_sel[q/8][(q%8)*4 +: 4];
            c[q] = lo_flags[q*4 + int'(f[1:0])] ^ f[2];
        end
        return c;
    endfunction

    function automatic logic [31:0] m_reg(input logic [2:0] a);
        case (a)
            3'd4: return m_en_lo;
            3'd5: return m_en_up;
            3'd6: return m_int_lo;
            3'd7: return m_int_up;
            default: return m_sel[a[1:0]];
        endcase
    endfunction

    task automatic m_reset();
        for (int w = 0; w < 4; w++) m_sel[w] = '0;
        m_en_lo = '0; m_en_up = '0; m_int_lo = '0; m_int_up = '0;
        m_prev_lo = '1; m_prev_up = '1; m_irq_lo = 1'b0; m_irq_up = 1'b0;
    endtask

    // Model one clock edge using the inputs currently driven.
    task automatic m_step(input logic we, input logic [2:0] wa, input logic [31:0] wd);
        logic [31:0] cl, cu;
        logic st;
        cl = lo_cond();
        cu = up_near_empty;
        st = m_sel[0][3];
        if (st) begin
            m_int_lo = (m_int_lo & ~((we && wa == 3'd6) ? wd : 32'h0)) | (cl & ~m_prev_lo);
            m_int_up = (m_int_up & ~((we && wa == 3'd7) ? wd : 32'h0)) | (cu & ~m_prev_up);
        end else begin
            m_int_lo = cl;
            m_int_up = cu;
        end
        m_prev_lo = cl;
        m_prev_up = cu;
        if (we) begin
            if (wa < 3'd4) m_sel[wa[1:0]] = wd;
            if (wa == 3'd4) m_en_lo = wd;
            if (wa == 3'd5) m_en_up = wd;
        end
        m_irq_lo = |(m_int_lo & m_en_lo);
        m_irq_up = |(m_int_up & m_en_up);
    endtask

    // One clock: drive at negedge, model at posedge, check at next negedge.
    task automatic tick(input logic we, input logic [2:0] wa, input logic [31:0] wd);
        string tg;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = rd_ptr;
        @(posedge clk);
        m_step(we, wa, wd);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6 irq_lo", {31'b0, irq_lo}, {31'b0, m_irq_lo});
        chk("R6 irq_up", {31'b0, irq_up}, {31'b0, m_irq_up});
        if (rd_ptr >= 3'd6) tg = m_sel[0][3] ? "R3 int word" : "R5 int word";
        else tg = "R7 readback";
        chk(tg, rd_data, m_reg(rd_ptr));
        rd_ptr = rd_ptr + 3'd1;
    endtask

    task automatic idle();
        tick(1'b0, 3'd0, 32'h0);
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'h0, "R8 reset reg");
        chk("R8 irq_lo reset", {31'b0, irq_lo}, 32'h0);
        chk("R8 irq_up reset", {31'b0, irq_up}, 32'h0);

        // R5: level mode during the write that enables sticky; all queues empty
        tick(1'b1, 3'd0, 32'h8);
        rd_chk(3'd6, 32'hFFFF_FFFF, "R5 level follows empty");
        // R3: clear in sticky mode
        tick(1'b1, 3'd6, 32'hFFFF_FFFF);
        rd_chk(3'd6, 32'h0, "R3 clear all");
        tick(1'b1, 3'd4, 32'hFFFF_FFFF);
        tick(1'b1, 3'd5, 32'hFFFF_FFFF);

        // R1/R3: queue 5 empty falls then rises
        lo_flags[20] = 1'b0; idle();
        rd_chk(3'd6, 32'h0, "R3 falling is not event");
        lo_flags[20] = 1'b1; idle();
        rd_chk(3'd6, 32'h20, "R1 empty rise sets q5");
        chk("R6 irq_lo after q5", {31'b0, irq_lo}, 32'h1);
        idle(); idle();
        rd_chk(3'd6, 32'h20, "R3 bit holds");

        // R4: new event and clear on the same clock
        lo_flags[20] = 1'b0; idle();
        lo_flags[20] = 1'b1; tick(1'b1, 3'd6, 32'h20);
        rd_chk(3'd6, 32'h20, "R4 set wins over clear");
        tick(1'b1, 3'd6, 32'h20);
        rd_chk(3'd6, 32'h0, "R3 clear q5");

        // R2: upper queue 8 nearly-empty rise
        up_near_empty[8] = 1'b1; idle();
        rd_chk(3'd7, 32'h100, "R2 upper near-empty");
        chk("R2 irq_up", {31'b0, irq_up}, 32'h1);

        // R9: queue 9 field = 0xA selects nearly-full, bit 3 ignored
        tick(1'b1, 3'd1, 32'h0000_00A0);
        tick(1'b1, 3'd6, 32'hFFFF_FFFF);
        lo_flags[38] = 1'b1; idle();
        rd_chk(3'd6, 32'h200, "R9 field bit3 ignored");
        tick(1'b1, 3'd6, 32'hFFFF_FFFF);

        // R10: queue 3 switched from empty to full selection
        lo_flags[12] = 1'b0; lo_flags[15] = 1'b1; idle();
        tick(1'b1, 3'd0, 32'h0000_3008);
        rd_chk(3'd6, 32'h0, "R10 selector not yet active");
        idle();
        rd_chk(3'd6, 32'h8, "R10 selector change is event");

        // R5: back to level mode; clear writes ignored
        tick(1'b1, 3'd0, 32'h0);
        tick(1'b1, 3'd6, 32'hFFFF_FFFF);
        rd_chk(3'd6, lo_cond(), "R5 clear ignored in level");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic we;
            logic [2:0] wa;
            logic [31:0] wd;
            if ($urandom % 2 == 0) lo_flags[$urandom % 128] ^= 1'b1;
            if ($urandom % 3 == 0) up_near_empty[$urandom % 32] ^= 1'b1;
            we = ($urandom % 4 == 0);
            wa = 3'($urandom % 8);
            wd = $urandom;
            if (wa == 3'd0) wd[3] = ($urandom % 4 != 0);
            tick(we, wa, wd);
        end
        finish_run();
    end
endmodule